// File: doc/BRIEF.md
# Scanline Vertical Timing Generator

This block counts the scan lines of a video frame and derives the vertical timing from that count. The horizontal timing generator sends it a one-cycle end-of-line strobe. Each counted strobe moves a 10-bit line counter forward by one. The counter runs from 0 up to a programmed total and then wraps back to 0. A control bit can make the counter step on every second strobe instead of every strobe, which doubles the frame height the counter can reach.

Every programmed boundary is the counter value at the start of a line. The active-display flag is high on lines below the display-end value. The blank flag and the sync flag are both set/clear windows:

- The blank window opens on a full 10-bit match with its start value. It closes on an 8-bit match of the low counter bits.
- The sync window opens on a full 10-bit match with its start value. It closes on a 4-bit match of the low counter bits.

Because the close matches use only low bits, either window can run past the wrap into the next frame. A sync-enable input forces the sync output low. An end-of-frame strobe marks each wrap.

The register fields that make up each boundary value are joined outside this block, so every boundary arrives here as a plain vector. All outputs come from registers and change only in the clock cycle after a counted strobe.

Top module: `svt_vtiming`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first counted strobe, `line_o` reads 0 and `vde_o`, `vblank_o`, `vsync_o` and `eof_o` are all 0.
- R2: Each counted strobe changes `line_o` to `line_o`+1. If `line_o` equals `vtotal_i`, it changes to 0 instead, so a frame lasts `vtotal_i`+1 lines.
- R3: With `line_div2_i` at 1, only every second `eol_i` strobe is counted. The first strobe after reset, or after the bit is set, is not counted. With `line_div2_i` at 0, every strobe is counted.
- R4: After a counted strobe, `vde_o` is 1 exactly when the new line count is below `vdisp_end_i`.
- R5: `vblank_o` becomes 1 on the line whose count equals `vblank_start_i`. It becomes 0 on the first later line whose count bits [7:0] equal `vblank_end_i`. If both match on the same line, the start wins. The window carries across the wrap.
- R6: The sync window opens on the line whose count equals `vsync_start_i`. It closes on the first later line whose count bits [3:0] equal `vsync_end_i`. If both match on the same line, the start wins. The window carries across the wrap.
- R7: `vsync_o` equals the sync window ANDed with `sync_en_i`, where `sync_en_i` is sampled at the counted strobe. With `sync_en_i` at 0, `vsync_o` is 0 on every line.
- R8: `eof_o` is 1 for exactly one clock cycle: the cycle after a counted strobe that wraps the counter. In that cycle `line_o` reads 0.
- R9: In a cycle that follows no counted strobe, `line_o`, `vde_o`, `vblank_o` and `vsync_o` keep their values. This includes strobes skipped in divide-by-2 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eol_i | input | 1 | End-of-line strobe, one cycle wide |
| line_div2_i | input | 1 | Count every second strobe when 1 |
| sync_en_i | input | 1 | Allows vertical sync when 1 |
| vtotal_i | input | 10 | Count of the last line in a frame |
| vdisp_end_i | input | 10 | Count of the first line after active display |
| vblank_start_i | input | 10 | Count of the first blanked line |
| vblank_end_i | input | 8 | Low 8 bits of the count of the first line after blanking |
| vsync_start_i | input | 10 | Count of the first sync line |
| vsync_end_i | input | 4 | Low 4 bits of the count of the first line after sync |
| line_o | output | 10 | Current line count |
| vde_o | output | 1 | Vertical active display |
| vblank_o | output | 1 | Vertical blank |
| vsync_o | output | 1 | Vertical sync |
| eof_o | output | 1 | End-of-frame strobe |

## Verification
The hardest cases to reach are windows whose close match lands in the next frame. One is a blank that closes on an 8-bit low match after the counter has passed 255. The other is a sync window whose 4-bit close value is only met again after the wrap. The stimulus builds a 301-line frame with blank and sync starting near its end, and a short frame run in divide-by-2 mode with windows that straddle the wrap. The bench works out every expected flag by walking back through the line sequence from the current line to the most recent start or close match, so no state machine is copied. A degenerate setup, where start and close match on the same line, exercises the start-wins rule.

// File: rtl/svt_pkg.sv
package svt_pkg;
  localparam int LINE_W_DEF      = 10;
  localparam int BLANK_END_W_DEF = 8;
  localparam int SYNC_END_W_DEF  = 4;
endpackage

// File: rtl/svt_line_clock.sv
module svt_line_clock (
  input  logic clk,
  input  logic rst_n,
  input  logic eol_i,
  input  logic div2_i,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= 1'b0;
    else if (!div2_i) phase_q <= 1'b0;
    else if (eol_i)   phase_q <= ~phase_q;
  end

  assign tick_o = eol_i & (~div2_i | phase_q);
endmodule

// File: rtl/svt_line_counter.sv
module svt_line_counter #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [LINE_W-1:0] total_i,
  output logic [LINE_W-1:0] line_o,
  output logic [LINE_W-1:0] next_o,
  output logic              wrap_o
);
  function automatic logic [LINE_W-1:0] step_line(input logic [LINE_W-1:0] cur,
                                                  input logic [LINE_W-1:0] tot);
    return (cur == tot) ? '0 : cur + 1'b1;
  endfunction

  logic [LINE_W-1:0] line_q;

  assign next_o = step_line(line_q, total_i);
  assign wrap_o = tick_i && (line_q == total_i);
  assign line_o = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      line_q <= '0;
    else if (tick_i) line_q <= next_o;
  end
endmodule

// File: rtl/svt_window.sv
module svt_window #(
  parameter int LINE_W = 10,
  parameter int END_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] start_i,
  input  logic [END_W-1:0]  end_i,
  input  logic              gate_i,
  output logic              active_o
);
  localparam int CMP_W = (END_W < LINE_W) ? END_W : LINE_W;

  function automatic logic low_match(input logic [LINE_W-1:0] ln,
                                     input logic [END_W-1:0]  ev);
    return ln[CMP_W-1:0] == ev[CMP_W-1:0];
  endfunction

  logic state_q, state_d, out_q;

  always_comb begin
    state_d = state_q;
    if (line_i == start_i)          state_d = 1'b1;
    else if (low_match(line_i, end_i)) state_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      out_q   <= 1'b0;
    end else if (tick_i) begin
      state_q <= state_d;
      out_q   <= state_d & gate_i;
    end
  end

  assign active_o = out_q;
endmodule

// File: rtl/svt_vtiming.sv
module svt_vtiming #(
  parameter int LINE_W      = svt_pkg::LINE_W_DEF,
  parameter int BLANK_END_W = svt_pkg::BLANK_END_W_DEF,
  parameter int SYNC_END_W  = svt_pkg::SYNC_END_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eol_i,
  input  logic                   line_div2_i,
  input  logic                   sync_en_i,
  input  logic [LINE_W-1:0]      vtotal_i,
  input  logic [LINE_W-1:0]      vdisp_end_i,
  input  logic [LINE_W-1:0]      vblank_start_i,
  input  logic [BLANK_END_W-1:0] vblank_end_i,
  input  logic [LINE_W-1:0]      vsync_start_i,
  input  logic [SYNC_END_W-1:0]  vsync_end_i,
  output logic [LINE_W-1:0]      line_o,
  output logic                   vde_o,
  output logic                   vblank_o,
  output logic                   vsync_o,
  output logic                   eof_o
);
  logic              line_tick;
  logic              line_wrap;
  logic [LINE_W-1:0] line_next;
  logic              vde_q, eof_q;

  svt_line_clock u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .eol_i  (eol_i),
    .div2_i (line_div2_i),
    .tick_o (line_tick)
  );

  svt_line_counter #(.LINE_W(LINE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (line_tick),
    .total_i (vtotal_i),
    .line_o  (line_o),
    .next_o  (line_next),
    .wrap_o  (line_wrap)
  );

  svt_window #(.LINE_W(LINE_W), .END_W(BLANK_END_W)) u_blank (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (line_tick),
    .line_i   (line_next),
    .start_i  (vblank_start_i),
    .end_i    (vblank_end_i),
    .gate_i   (1'b1),
    .active_o (vblank_o)
  );

  svt_window #(.LINE_W(LINE_W), .END_W(SYNC_END_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (line_tick),
    .line_i   (line_next),
    .start_i  (vsync_start_i),
    .end_i    (vsync_end_i),
    .gate_i   (sync_en_i),
    .active_o (vsync_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vde_q <= 1'b0;
      eof_q <= 1'b0;
    end else begin
      eof_q <= line_wrap;
      if (line_tick) vde_q <= (line_next < vdisp_end_i);
    end
  end

  assign vde_o = vde_q;
  assign eof_o = eof_q;
endmodule

// File: rtl/svt_vtiming_checks.sv
module svt_vtiming_checks #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_div2_i,
  input logic              sync_en_i,
  input logic [LINE_W-1:0] vtotal_i,
  input logic [LINE_W-1:0] line_o,
  input logic              vde_o,
  input logic              vblank_o,
  input logic              vsync_o,
  input logic              eof_o,
  input logic              line_tick
);
  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && line_o != vtotal_i) |=> line_o == LINE_W'($past(line_o) + 1'b1));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && line_o == vtotal_i) |=> (line_o == '0) && eof_o);

  p_div2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_div2_i && line_tick) |=> (!line_tick || !line_div2_i));

  p_sync_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && !sync_en_i) |=> !vsync_o);

  p_eof_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> line_o == '0);

  p_eof_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> $past(line_tick));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> ($stable(line_o) && $stable(vde_o) && $stable(vblank_o) && $stable(vsync_o)));
endmodule

bind svt_vtiming svt_vtiming_checks #(.LINE_W(LINE_W)) u_checks (.*);

// File: tb/tb_svt_vtiming.sv
`timescale 1ns/1ps
module tb_svt_vtiming;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       eol = 1'b0;
  logic       div2 = 1'b0;
  logic       sen = 1'b1;
  logic [9:0] vt = '0, de = '0, bs = '0, vs = '0;
  logic [7:0] be = '0;
  logic [3:0] ve = '0;
  logic [9:0] line;
  logic       vde, vblank, vsync, eof;

  int n_checks = 0, n_err = 0;
  int m_line, m_n;
  bit m_phase, e_vde, e_vb, e_vs;

  always #2 clk = ~clk;

  svt_vtiming dut (
    .clk(clk), .rst_n(rst_n), .eol_i(eol), .line_div2_i(div2), .sync_en_i(sen),
    .vtotal_i(vt), .vdisp_end_i(de), .vblank_start_i(bs), .vblank_end_i(be),
    .vsync_start_i(vs), .vsync_end_i(ve),
    .line_o(line), .vde_o(vde), .vblank_o(vblank), .vsync_o(vsync), .eof_o(eof)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Walk back over the visited lines to the most recent start or close match.
  function automatic bit win_state(input int cur, input int n, input int tot,
                                   input int st, input int en, input int mask);
    int len = tot + 1;
    int lim = (n < 2 * len) ? n : 2 * len;
    for (int k = 0; k < lim; k++) begin
      int l = (((cur - k) % len) + len) % len;
      if (l == st) return 1'b1;
      if ((l & mask) == en) return 1'b0;
    end
    return 1'b0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; eol = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "line", line, 0);
    chk("R1", "vde", vde, 0);
    chk("R1", "vblank", vblank, 0);
    chk("R1", "vsync", vsync, 0);
    chk("R1", "eof", eof, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "line after release", line, 0);
    chk("R1", "vde after release", vde, 0);
    m_line = 0; m_n = 0; m_phase = 0; e_vde = 0; e_vb = 0; e_vs = 0;
  endtask

  task automatic pulse();
    bit tick, wrapped;
    int prev;
    @(negedge clk);
    eol = 1'b1;
    wrapped = 0;
    if (div2) begin tick = m_phase; m_phase = !m_phase; end
    else begin tick = 1; m_phase = 0; end
    if (tick) begin
      prev = m_line;
      m_line = (m_line == int'(vt)) ? 0 : m_line + 1;
      wrapped = (prev == int'(vt));
      m_n++;
      e_vde = (m_line < int'(de));
      e_vb = win_state(m_line, m_n, vt, bs, be, 255);
      e_vs = win_state(m_line, m_n, vt, vs, ve, 15) && sen;
    end
    @(negedge clk);
    eol = 1'b0;
    chk(div2 ? "R3" : "R2", "line", line, m_line);
    chk("R4", "vde", vde, e_vde);
    chk("R5", "vblank", vblank, e_vb);
    chk(sen ? "R6" : "R7", "vsync", vsync, e_vs);
    chk("R8", "eof", eof, wrapped);
    @(negedge clk);
    chk("R8", "eof one cycle", eof, 0);
    chk("R9", "line hold", line, m_line);
    chk("R9", "vblank hold", vblank, e_vb);
    chk("R9", "vsync hold", vsync, e_vs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    // A: plain counting, windows inside the frame
    vt = 19; de = 12; bs = 14; be = 18; vs = 15; ve = 4'd1; div2 = 0; sen = 1;
    do_reset();
    for (int i = 0; i < 60; i++) pulse();

    // B: divide by 2, windows across the wrap, sync enable toggled per frame
    vt = 19; de = 16; bs = 17; be = 3; vs = 18; ve = 4'd2; div2 = 1; sen = 1;
    do_reset();
    for (int f = 0; f < 4; f++) begin
      sen = (f % 2 == 0);
      for (int i = 0; i < 40; i++) pulse();
    end

    // C: start and close on the same line, no active display
    vt = 9; de = 0; bs = 5; be = 5; vs = 4; ve = 4'd4; div2 = 0; sen = 1;
    do_reset();
    for (int i = 0; i < 25; i++) pulse();

    // D: long frame, 8-bit and 4-bit close after the wrap
    vt = 300; de = 280; bs = 290; be = 20; vs = 295; ve = 4'd3; div2 = 0; sen = 1;
    do_reset();
    for (int i = 0; i < 640; i++) pulse();

    // E: sync disabled for a whole frame
    vt = 19; de = 12; bs = 14; be = 18; vs = 15; ve = 4'd1; div2 = 0; sen = 0;
    do_reset();
    for (int i = 0; i < 25; i++) pulse();

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule